// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block provides two 16-bit counting channels, each split into a low byte and a high byte. A channel advances either on the machine-cycle enable strobe (timer use) or on falling edges seen at its count pin (event-counting use). The pin is sampled once per machine-cycle strobe. A shared mode register picks one of four count structures per channel: a 13-bit count made of a 5-bit prescaler and an 8-bit byte, a plain 16-bit count, an 8-bit count that reloads from the high byte, or, on channel 0 only, two independent 8-bit counters.

A small write-only register bus sets the modes, the run bits, the overflow flags and the four count bytes. Each channel raises a sticky overflow flag when it rolls over. An acknowledge input clears the flag, for example from an interrupt controller when it takes the request. Every rollover of channel 1 also produces a one-cycle tick that a serial baud-rate divider can use.

Register addresses are as follows: 0 is the mode register, 1 is the control register, 2 and 3 are the channel 0 low and high bytes, and 4 and 5 are the channel 1 low and high bytes. In the mode register, channel 0 uses bits [3:0] and channel 1 uses bits [7:4]. Each nibble is laid out as {gate, pin_select, mode[1:0]}. The mode codes are: 00 for the 13-bit count, 01 for the 16-bit count, 10 for the 8-bit reload, and 11 for the split mode. The control register holds run0 at bit 0, run1 at bit 1, flag0 at bit 2 and flag1 at bit 3.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset both counts, the mode register, the run bits, both flags and the baud tick are all zero.
- R2: With pin_select=0 a running channel advances by exactly one on each clock where mc_en_i is high, and holds on every clock where it is low.
- R3: With pin_select=1 a running channel advances by one when the count pin was sampled high at one mc_en_i strobe and is sampled low at the next strobe; pin activity between strobes is not seen.
- R4: With gate=1 a channel advances only while its run bit is 1 and its gate pin is high; with gate=0 the run bit alone enables it, and with both run bits at 0 no count moves.
- R5: Mode 00 counts with low-byte bits [4:0] as a prescaler that carries into the high byte. Low-byte bits [7:5] hold their value. The channel overflows when the count steps from high=FF, prescaler=1F to zero.
- R6: Mode 01 counts the full 16 bits and overflows when it steps from FFFF to 0000.
- R7: Mode 10 counts the low byte, and on a step from FF it loads the high byte into the low byte and overflows; the high byte is unchanged.
- R8: When channel 0 is in mode 11, three things apply. Its low byte counts as an 8-bit counter under run0, gate0 and pin_select0, and sets flag0. Its high byte counts machine cycles under run1 and sets flag1. A channel 1 overflow no longer sets flag1. A channel set to mode 11 otherwise holds its count.
- R9: A flag sets on overflow of its source. A flag clears when its acknowledge bit or a control-register write of 0 acts on it. A set in the same cycle wins over a clear.
- R10: A count byte written by the bus holds the written value after that clock edge, and the channel's increment for that cycle is dropped.
- R11: baud_tick_o is high for exactly the cycle after each channel 1 overflow, whatever the mode of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mc_en_i | input | 1 | Machine-cycle strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | Gate pins, one per channel |
| ovf_ack_i | input | 2 | Overflow flag acknowledge, one per channel |
| cnt0_o | output | 16 | Channel 0 count {high, low} |
| cnt1_o | output | 16 | Channel 1 count {high, low} |
| ovf_flag_o | output | 2 | Overflow flags |
| baud_tick_o | output | 1 | One-cycle pulse per channel 1 overflow |

## Verification
Some properties are checked on every cycle. Counts hold when there is no strobe or no run bit. Channel 1 holds while it is in mode 11. A byte write lands unchanged. The reload step copies the high byte. A baud tick outside split mode always comes with flag1. Other behaviours can only be shown by the bench's scenarios, because they need a known start value and a counted number of strobes: the prescaler carry, the wrap points of each mode, falling-edge detection across strobes, gating by the pin, flag routing in split mode, and set-over-clear priority on the flags.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int ADDR_W = 3;
    localparam int CFG_W  = 4;

    typedef enum logic [1:0] {
        TM_PRE13   = 2'b00,
        TM_FULL16  = 2'b01,
        TM_RELOAD8 = 2'b10,
        TM_SPLIT   = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      pin_sel;
        tmr_mode_e mode;
    } ch_cfg_t;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;

    // address of a channel count byte: low at 2+2c, high at 3+2c
    function automatic logic [ADDR_W-1:0] byte_addr(input int ch, input logic hi);
        return ADDR_W'(2 + 2 * ch + (hi ? 1 : 0));
    endfunction

endpackage

// File: rtl/tmr_edge_sampler.sv
`timescale 1ns/1ps
module tmr_edge_sampler #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         mc_en_i,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] samp_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        samp_q <= '0;
        else if (mc_en_i) samp_q <= pin_i;
    end

    // previous strobe saw high, this strobe sees low
    assign fall_o = {N{mc_en_i}} & samp_q & ~pin_i;
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] hw_set_i,
    input  logic [N-1:0] ack_i,
    input  logic         sw_we_i,
    input  logic [N-1:0] sw_val_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) flag_q <= '0;
        else       flag_q <= hw_set_i | (sw_we_i ? sw_val_i : (flag_q & ~ack_i));
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int BW       = BYTE_W,
    parameter int PW       = PRE_W,
    parameter bit SPLIT_EN = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  tmr_mode_e     mode_i,
    input  logic          inc_main_i,
    input  logic          inc_hi_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] lo_o,
    output logic [BW-1:0] hi_o,
    output logic          ovf_main_o,
    output logic          ovf_hi_o
);
    localparam logic [BW-1:0] BYTE_MAX = {BW{1'b1}};
    localparam logic [PW-1:0] PRE_MAX  = {PW{1'b1}};

    logic [BW-1:0]   lo_q, hi_q, lo_n, hi_n;
    logic [2*BW-1:0] full_inc;
    logic [PW-1:0]   pre_inc;
    logic            ovf_m, ovf_h, wr_any;
    logic            split_lo_step, split_hi_step;
    logic            split_lo_ovf, split_hi_ovf;
    logic [BW-1:0]   split_lo_n, split_hi_n;

    assign full_inc = {hi_q, lo_q} + 1'b1;
    assign pre_inc  = lo_q[PW-1:0] + 1'b1;
    assign wr_any   = wr_lo_i | wr_hi_i;

    generate
        if (SPLIT_EN) begin : g_split
            // two independent byte counters
            assign split_lo_step = inc_main_i;
            assign split_hi_step = inc_hi_i;
            assign split_lo_ovf  = inc_main_i && (lo_q == BYTE_MAX);
            assign split_hi_ovf  = inc_hi_i && (hi_q == BYTE_MAX);
            assign split_lo_n    = lo_q + 1'b1;
            assign split_hi_n    = hi_q + 1'b1;
        end else begin : g_halt
            // mode 11 freezes this channel
            assign split_lo_step = 1'b0;
            assign split_hi_step = 1'b0;
            assign split_lo_ovf  = 1'b0;
            assign split_hi_ovf  = inc_hi_i & 1'b0;
            assign split_lo_n    = lo_q;
            assign split_hi_n    = hi_q;
        end
    endgenerate

    always_comb begin
        lo_n  = lo_q;
        hi_n  = hi_q;
        ovf_m = 1'b0;
        ovf_h = 1'b0;
        unique case (mode_i)
            TM_PRE13: begin
                if (inc_main_i) begin
                    lo_n[PW-1:0] = pre_inc;
                    if (lo_q[PW-1:0] == PRE_MAX) begin
                        hi_n  = hi_q + 1'b1;
                        ovf_m = (hi_q == BYTE_MAX);
                    end
                end
            end
            TM_FULL16: begin
                if (inc_main_i) begin
                    {hi_n, lo_n} = full_inc;
                    ovf_m        = ({hi_q, lo_q} == {BYTE_MAX, BYTE_MAX});
                end
            end
            TM_RELOAD8: begin
                if (inc_main_i) begin
                    if (lo_q == BYTE_MAX) begin
                        lo_n  = hi_q;
                        ovf_m = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            TM_SPLIT: begin
                if (split_lo_step) lo_n = split_lo_n;
                if (split_hi_step) hi_n = split_hi_n;
                ovf_m = split_lo_ovf;
                ovf_h = split_hi_ovf;
            end
            default: ;
        endcase
        // a bus write replaces the byte and drops this cycle's step
        if (wr_any) begin
            lo_n  = wr_lo_i ? wdata_i : lo_q;
            hi_n  = wr_hi_i ? wdata_i : hi_q;
            ovf_m = 1'b0;
            ovf_h = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo_o       = lo_q;
    assign hi_o       = hi_q;
    assign ovf_main_o = ovf_m;
    assign ovf_hi_o   = ovf_h;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int PW = PRE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          mc_en_i,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [BW-1:0] bus_wdata_i,
    input  logic [1:0]    cnt_pin_i,
    input  logic [1:0]    gate_pin_i,
    input  logic [1:0]    ovf_ack_i,
    output logic [2*BW-1:0] cnt0_o,
    output logic [2*BW-1:0] cnt1_o,
    output logic [1:0]    ovf_flag_o,
    output logic          baud_tick_o
);
    localparam int NCH    = 2;
    localparam int MODE_W = NCH * CFG_W;

    logic [MODE_W-1:0]         mode_q;
    logic [NCH-1:0]            run_q;
    logic                      baud_q;
    ch_cfg_t [NCH-1:0]         cfg;
    logic [NCH-1:0]            fall, enab, inc_main, ovf_main, ovf_hi, flag_set;
    logic [NCH-1:0][BW-1:0]    lo, hi;
    logic                      split_on, we_mode, we_ctrl;

    assign we_mode  = bus_we_i && (bus_addr_i == AW'(A_MODE));
    assign we_ctrl  = bus_we_i && (bus_addr_i == AW'(A_CTRL));
    assign split_on = (cfg[0].mode == TM_SPLIT);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= '0;
            run_q  <= '0;
            baud_q <= 1'b0;
        end else begin
            if (we_mode) mode_q <= bus_wdata_i[MODE_W-1:0];
            if (we_ctrl) run_q  <= bus_wdata_i[NCH-1:0];
            baud_q <= ovf_main[1];
        end
    end

    tmr_edge_sampler #(.N(NCH)) u_samp (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .mc_en_i (mc_en_i),
        .pin_i   (cnt_pin_i),
        .fall_o  (fall)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign cfg[c]      = ch_cfg_t'(mode_q[c*CFG_W +: CFG_W]);
            assign enab[c]     = run_q[c] & (~cfg[c].gate | gate_pin_i[c]);
            assign inc_main[c] = enab[c] & (cfg[c].pin_sel ? fall[c] : mc_en_i);

            logic inc_hi;
            if (c == 0) begin : g_hi_src
                // split high byte: machine cycles under channel 1 run bit
                assign inc_hi = run_q[1] & mc_en_i;
            end else begin : g_hi_none
                assign inc_hi = 1'b0;
            end

            tmr_channel #(
                .BW       (BW),
                .PW       (PW),
                .SPLIT_EN (c == 0)
            ) u_ch (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .mode_i     (cfg[c].mode),
                .inc_main_i (inc_main[c]),
                .inc_hi_i   (inc_hi),
                .wr_lo_i    (bus_we_i && (bus_addr_i == byte_addr(c, 1'b0))),
                .wr_hi_i    (bus_we_i && (bus_addr_i == byte_addr(c, 1'b1))),
                .wdata_i    (bus_wdata_i),
                .lo_o       (lo[c]),
                .hi_o       (hi[c]),
                .ovf_main_o (ovf_main[c]),
                .ovf_hi_o   (ovf_hi[c])
            );
        end
    endgenerate

    // flag 1 follows channel 0 high byte while channel 0 is split
    assign flag_set[0] = ovf_main[0];
    assign flag_set[1] = split_on ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

    tmr_flags #(.N(NCH)) u_flags (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hw_set_i (flag_set),
        .ack_i    (ovf_ack_i),
        .sw_we_i  (we_ctrl),
        .sw_val_i (bus_wdata_i[NCH+1:NCH]),
        .flag_o   (ovf_flag_o)
    );

    assign cnt0_o      = {hi[0], lo[0]};
    assign cnt1_o      = {hi[1], lo[1]};
    assign baud_tick_o = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        mc_en_i,
    input logic        bus_we_i,
    input logic [2:0]  bus_addr_i,
    input logic [7:0]  bus_wdata_i,
    input logic [15:0] cnt0_o,
    input logic [15:0] cnt1_o,
    input logic [1:0]  ovf_flag_o,
    input logic        baud_tick_o,
    input logic [7:0]  mode_q,
    input logic [1:0]  run_q
);
    AST_IDLE_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mc_en_i && !bus_we_i) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R2

    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q == 2'b00 && !bus_we_i) |=> ($stable(cnt0_o) && $stable(cnt1_o))); // R4

    AST_RELOAD_COPIES_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q[7:4] == 4'b0010 && run_q[1] && mc_en_i && !bus_we_i && cnt1_o[7:0] == 8'hFF)
        |=> (cnt1_o[7:0] == $past(cnt1_o[15:8]))); // R7

    AST_SPLIT_HALTS_CH1: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q[5:4] == 2'b11 && !bus_we_i) |=> $stable(cnt1_o)); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_we_i && bus_addr_i == 3'd2) |=> (cnt0_o[7:0] == $past(bus_wdata_i))); // R10

    AST_TICK_WITH_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (baud_tick_o && $past(mode_q[1:0]) != 2'b11) |-> ovf_flag_o[1]); // R11
endmodule

bind tmr_pair tmr_pair_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mc_en_i     (mc_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt0_o      (cnt0_o),
    .cnt1_o      (cnt1_o),
    .ovf_flag_o  (ovf_flag_o),
    .baud_tick_o (baud_tick_o),
    .mode_q      (mode_q),
    .run_q       (run_q)
);

// File: tb/tmr_pair_tb_top.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mc_en = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  cnt_pin = '0;
    logic [1:0]  gate_pin = '0;
    logic [1:0]  ack = '0;
    logic [15:0] cnt0, cnt1;
    logic [1:0]  flags;
    logic        btick;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tmr_pair dut_i (
        .clk_i (clk), .rst_i (rst), .mc_en_i (mc_en),
        .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata),
        .cnt_pin_i (cnt_pin), .gate_pin_i (gate_pin), .ovf_ack_i (ack),
        .cnt0_o (cnt0), .cnt1_o (cnt1), .ovf_flag_o (flags), .baud_tick_o (btick)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] start;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 16'h0010, 8'd5, 16'h0015, 1'b0},
        '{2'b01, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
        '{2'b00, 16'h12FE, 8'd3, 16'h13E1, 1'b0},
        '{2'b00, 16'hFFFF, 8'd1, 16'h00E0, 1'b1},
        '{2'b10, 16'hF0FD, 8'd4, 16'hF0F1, 1'b1},
        '{2'b10, 16'h8000, 8'd3, 16'h8003, 1'b0}
    };

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R5";
            2'b01:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic run_mc(input int n);
        @(negedge clk);
        mc_en = 1'b1;
        repeat (n) @(negedge clk);
        mc_en = 1'b0;
    endtask

    task automatic load(input int ch, input logic [15:0] v);
        bus_wr(3'(2 + 2 * ch), v[7:0]);
        bus_wr(3'(3 + 2 * ch), v[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", cnt0, 16'h0000);
        chk("R1", cnt1, 16'h0000);
        chk("R1", {13'd0, flags, btick}, 16'h0000);

        // table of mode vectors on channel 0
        for (int i = 0; i < 6; i++) begin
            bus_wr(3'd1, 8'h00);
            bus_wr(3'd0, {6'd0, VECS[i].mode});
            load(0, VECS[i].start);
            bus_wr(3'd1, 8'h01);
            run_mc(int'(VECS[i].ticks));
            chk(mode_req(VECS[i].mode), cnt0, VECS[i].exp_cnt);
            chk(mode_req(VECS[i].mode), {15'd0, flags[0]}, {15'd0, VECS[i].exp_flag});
        end

        // R2 no strobe, no count
        bus_wr(3'd1, 8'h00);
        load(0, 16'h0100);
        bus_wr(3'd1, 8'h01);
        repeat (5) @(negedge clk);
        chk("R2", cnt0, 16'h0100);
        run_mc(2);
        chk("R2", cnt0, 16'h0102);

        // R4 gating by pin (gate=1, timer, mode 01)
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h09);
        load(0, 16'h0000);
        bus_wr(3'd1, 8'h01);
        gate_pin = 2'b00;
        run_mc(4);
        chk("R4", cnt0, 16'h0000);
        gate_pin = 2'b01;
        run_mc(3);
        chk("R4", cnt0, 16'h0003);
        gate_pin = 2'b00;

        // R3 falling edges on channel 1 pin, sampled per strobe
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h50);
        load(1, 16'h0000);
        bus_wr(3'd1, 8'h02);
        cnt_pin = 2'b10; run_mc(1);
        cnt_pin = 2'b00; run_mc(1);
        run_mc(1);
        cnt_pin = 2'b10; repeat (2) @(negedge clk);
        cnt_pin = 2'b00; repeat (2) @(negedge clk);
        run_mc(1);
        chk("R3", cnt1, 16'h0001);
        cnt_pin = 2'b10; run_mc(1);
        cnt_pin = 2'b00; run_mc(1);
        chk("R3", cnt1, 16'h0002);

        // R8 split mode: both channels mode 11
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h33);
        load(0, 16'h10FE);
        load(1, 16'h0500);
        bus_wr(3'd1, 8'h03);
        run_mc(3);
        chk("R8", cnt0, 16'h1301);
        chk("R8", cnt1, 16'h0500);
        chk("R8", {14'd0, flags}, 16'h0001);
        bus_wr(3'd1, 8'h02);
        load(0, 16'hFF01);
        run_mc(1);
        chk("R8", cnt0, 16'h0001);
        chk("R8", {14'd0, flags}, 16'h0002);

        // R9 acknowledge clears, set beats clear
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h01);
        load(0, 16'hFFFF);
        bus_wr(3'd1, 8'h01);
        run_mc(1);
        chk("R9", {15'd0, flags[0]}, 16'h0001);
        @(negedge clk); ack = 2'b01;
        @(negedge clk); ack = 2'b00;
        chk("R9", {15'd0, flags[0]}, 16'h0000);
        bus_wr(3'd1, 8'h00);
        load(0, 16'hFFFF);
        bus_wr(3'd1, 8'h01);
        @(negedge clk); mc_en = 1'b1; ack = 2'b01;
        @(negedge clk); mc_en = 1'b0; ack = 2'b00;
        chk("R9", {15'd0, flags[0]}, 16'h0001);
        chk("R9", cnt0, 16'h0000);

        // R10 write drops the step of that cycle
        bus_wr(3'd1, 8'h00);
        load(0, 16'h0000);
        bus_wr(3'd1, 8'h01);
        @(negedge clk); mc_en = 1'b1; we = 1'b1; addr = 3'd2; wdata = 8'h40;
        @(negedge clk); we = 1'b0;
        chk("R10", cnt0, 16'h0040);
        @(negedge clk); mc_en = 1'b0;
        chk("R10", cnt0, 16'h0041);

        // R11 baud tick from channel 1 reload mode
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h20);
        load(1, 16'hFEFE);
        bus_wr(3'd1, 8'h02);
        run_mc(1);
        chk("R11", {15'd0, btick}, 16'h0000);
        run_mc(1);
        chk("R11", {15'd0, btick}, 16'h0001);
        chk("R11", cnt1, 16'hFEFE);
        @(negedge clk);
        chk("R11", {15'd0, btick}, 16'h0000);

        // R11 and R8: channel 0 split, channel 1 overflow ticks without flag1
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd0, 8'h13);
        load(0, 16'h0000);
        load(1, 16'hFFFF);
        bus_wr(3'd1, 8'h02);
        run_mc(1);
        chk("R11", {15'd0, btick}, 16'h0001);
        chk("R8", {14'd0, flags}, 16'h0000);
        chk("R8", cnt0, 16'h0100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule